// File: doc/BRIEF.md
# PWM Timer with Released Match Update

This block is a counter driven by a programmable prescaler, with a bank of compare values. It has two modes. In PWM mode, compare value 0 sets the period and each other compare value sets where one single-edge output falls within that period. In timer mode, the same compare values raise flags and can restart or halt the counter. Software programs the block through a small word-addressed register port with a combinational read path.

In PWM mode a compare write only lands in a hidden holding copy. It reaches the live compare only after software sets the matching release bit, and then only at the next period restart. A new duty or period therefore never cuts a pulse short in the middle of a period. In timer mode writes go straight to the live compare.

Top module: `pwm_timer`

## Requirements
- R1: While the run bit is set and the hold bit is clear, the count advances by one every P+1 clocks, where P is the prescale register. The first advance happens P+1 clocks after run is written. While hold is set, the count and the prescale phase are forced to zero.
- R2: In PWM mode, a count advance that finds the count equal to live compare 0 takes the count back to 0. The count therefore cycles 0..M0.
- R3: PWM output k (bit k of `pwm_out`) follows live compare k+1. It is high while the count is below that compare, starting from the first period restart. It is low before the first restart. A compare of 0 keeps it low, and a compare above M0 keeps it high. In timer mode every output is low.
- R4: In PWM mode a compare write changes only the holding copy. Reading a compare address returns the live value, and that value stays unchanged while no release is pending.
- R5: Writing ones to the release register marks those compares as pending. At the next period restart each pending compare copies its holding value into the live value, and its pending bit clears.
- R6: In timer mode a compare write updates the live value at once.
- R7: Whenever the count advances while equal to live compare i, flag i sets. `irq` is high while any flag is set.
- R8: Writing a one to a flag bit clears that flag. Writing a zero leaves it as it was.
- R9: In timer mode, mode-control bit 2i makes a match on compare i take the count to 0 instead of incrementing it.
- R10: In timer mode, mode-control bit 2i+1 makes a match on compare i clear the run bit, and the count then stays where it is.
- R11: Register map, in word addresses: 0 control (bit0 run, bit1 hold, bit2 PWM mode), 1 prescale, 2 count (read only), 3 flags, 4 mode control, 5 release, 8+i compare i. After reset every register reads 0 and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| pwm_out | output | NUM_MATCH-1 | PWM outputs, bit k driven by compare k+1 |
| irq | output | 1 | High while any match flag is set |

## Verification
The hardest case to reach is a release that is still waiting for a period boundary. The duty has to keep its old value for the rest of the current period and switch exactly at the restart. The bench gets there by starting PWM with a known period, writing a new compare while the counter is running, and leaving it unreleased for several periods. It then sets the release bit at an arbitrary point in a period. From the clock on which the release write lands, it computes the first boundary that follows, and in every cycle it compares the output, the live compare readback and the pending bit against that boundary.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
    localparam logic [ADDR_W-1:0] A_PRESC = 4'd1;
    localparam logic [ADDR_W-1:0] A_COUNT = 4'd2;
    localparam logic [ADDR_W-1:0] A_FLAGS = 4'd3;
    localparam logic [ADDR_W-1:0] A_MCTL  = 4'd4;
    localparam logic [ADDR_W-1:0] A_REL   = 4'd5;

    // control word layout, LSB first: run, hold, pwm_mode
    typedef struct packed {
        logic pwm_mode;
        logic hold;
        logic run;
    } ctrl_t;

    // compare slots live at 8 + index
    function automatic logic slot_valid(input logic [ADDR_W-1:0] a, input int n);
        return a[3] && (int'(a[2:0]) < n);
    endfunction
endpackage

// File: rtl/pwmt_prescaler.sv
module pwmt_prescaler #(
    parameter int PRE_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             clear,
    input  logic [PRE_W-1:0] limit,
    output logic             tick
);
    logic [PRE_W-1:0] phase_q;
    logic             at_end;

    assign at_end = (phase_q >= limit);
    assign tick   = enable && at_end;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            phase_q <= '0;
        end else if (enable) begin
            phase_q <= at_end ? '0 : phase_q + PRE_W'(1);
        end
    end
endmodule

// File: rtl/pwmt_match_bank.sv
module pwmt_match_bank #(
    parameter int CNT_W     = 32,
    parameter int NUM_MATCH = 4,
    localparam int IDX_W    = (NUM_MATCH > 1) ? $clog2(NUM_MATCH) : 1
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                wr_en,
    input  logic [IDX_W-1:0]                    wr_idx,
    input  logic [CNT_W-1:0]                    wr_data,
    input  logic                                shadow_mode,
    input  logic [NUM_MATCH-1:0]                rel_set,
    input  logic                                apply,
    output logic [NUM_MATCH-1:0][CNT_W-1:0]     active,
    output logic [NUM_MATCH-1:0][CNT_W-1:0]     next_active,
    output logic [NUM_MATCH-1:0]                pending
);
    logic [CNT_W-1:0]     shadow_q [NUM_MATCH];
    logic [CNT_W-1:0]     active_q [NUM_MATCH];
    logic [NUM_MATCH-1:0] pend_q;

    for (genvar i = 0; i < NUM_MATCH; i++) begin : g_slot
        logic hit_wr, direct, release_now, load_act;
        logic [CNT_W-1:0] act_src;

        assign hit_wr      = wr_en && (wr_idx == IDX_W'(i));
        assign direct      = hit_wr && !shadow_mode;
        assign release_now = apply && pend_q[i];
        assign load_act    = direct || release_now;
        assign act_src     = direct ? wr_data : shadow_q[i];

        always_ff @(posedge clk) begin
            if (rst) begin
                shadow_q[i] <= '0;
                active_q[i] <= '0;
            end else begin
                if (hit_wr)   shadow_q[i] <= wr_data;
                if (load_act) active_q[i] <= act_src;
            end
        end

        assign active[i]      = active_q[i];
        assign next_active[i] = release_now ? shadow_q[i] : active_q[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~(apply ? pend_q : '0)) | rel_set;
        end
    end

    assign pending = pend_q;
endmodule

// File: rtl/pwmt_counter.sv
module pwmt_counter #(
    parameter int CNT_W     = 32,
    parameter int NUM_MATCH = 4
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            tick,
    input  logic                            hold,
    input  logic                            pwm_mode,
    input  logic [NUM_MATCH-1:0][CNT_W-1:0] active,
    input  logic [NUM_MATCH-1:0]            reset_sel,
    input  logic [NUM_MATCH-1:0]            stop_sel,
    output logic [CNT_W-1:0]                count,
    output logic [NUM_MATCH-1:0]            hit,
    output logic                            wrap,
    output logic                            stop_req
);
    logic [CNT_W-1:0] count_q;

    for (genvar i = 0; i < NUM_MATCH; i++) begin : g_cmp
        assign hit[i] = tick && (count_q == active[i]);
    end

    assign wrap     = pwm_mode ? hit[0] : |(hit & reset_sel);
    assign stop_req = !pwm_mode && |(hit & stop_sel);

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            count_q <= '0;
        end else if (wrap) begin
            count_q <= '0;
        end else if (tick) begin
            count_q <= count_q + CNT_W'(1);
        end
    end

    assign count = count_q;
endmodule

// File: rtl/pwmt_outputs.sv
module pwmt_outputs #(
    parameter int CNT_W     = 32,
    parameter int NUM_MATCH = 4,
    localparam int NUM_OUT  = NUM_MATCH - 1
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            pwm_mode,
    input  logic                            tick,
    input  logic                            wrap,
    input  logic [CNT_W-1:0]                count,
    input  logic [NUM_MATCH-1:0][CNT_W-1:0] next_active,
    output logic [NUM_OUT-1:0]              pwm_out
);
    logic [CNT_W-1:0] count_inc;
    assign count_inc = count + CNT_W'(1);

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
        logic level_q;
        always_ff @(posedge clk) begin
            if (rst || !pwm_mode) begin
                level_q <= 1'b0;
            end else if (wrap) begin
                level_q <= (next_active[k+1] != '0);
            end else if (tick && (count_inc == next_active[k+1])) begin
                level_q <= 1'b0;
            end
        end
        assign pwm_out[k] = level_q;
    end
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
    import pwmt_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int PRE_W     = 32,
    parameter int NUM_MATCH = 4,
    localparam int NUM_OUT  = NUM_MATCH - 1,
    localparam int IDX_W    = (NUM_MATCH > 1) ? $clog2(NUM_MATCH) : 1,
    localparam int MCTL_W   = 2 * NUM_MATCH
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_we,
    input  logic [3:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic [NUM_OUT-1:0] pwm_out,
    output logic               irq
);
    ctrl_t                           ctrl_q, ctrl_d;
    logic [PRE_W-1:0]                presc_q;
    logic [MCTL_W-1:0]               mctl_q;
    logic [NUM_MATCH-1:0]            flags_q;

    logic                            pwm_mode, hold, run_en;
    logic                            wr_ctrl, wr_presc, wr_flags, wr_mctl, wr_rel, wr_match;
    logic                            tick, wrap, stop_req;
    logic [CNT_W-1:0]                count;
    logic [NUM_MATCH-1:0]            hit, reset_sel, stop_sel, pending, rel_set;
    logic [NUM_MATCH-1:0][CNT_W-1:0] active, next_active;
    logic [IDX_W-1:0]                slot_idx;

    assign pwm_mode = ctrl_q.pwm_mode;
    assign hold     = ctrl_q.hold;
    assign run_en   = ctrl_q.run && !ctrl_q.hold;

    assign wr_ctrl  = reg_we && (reg_addr == A_CTRL);
    assign wr_presc = reg_we && (reg_addr == A_PRESC);
    assign wr_flags = reg_we && (reg_addr == A_FLAGS);
    assign wr_mctl  = reg_we && (reg_addr == A_MCTL);
    assign wr_rel   = reg_we && (reg_addr == A_REL);
    assign wr_match = reg_we && slot_valid(reg_addr, NUM_MATCH);
    assign slot_idx = reg_addr[IDX_W-1:0];
    assign rel_set  = wr_rel ? reg_wdata[NUM_MATCH-1:0] : '0;

    for (genvar i = 0; i < NUM_MATCH; i++) begin : g_mctl
        assign reset_sel[i] = mctl_q[2*i];
        assign stop_sel[i]  = mctl_q[2*i+1];
    end

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_ctrl)  ctrl_d = ctrl_t'(reg_wdata[2:0]);
        if (stop_req) ctrl_d.run = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            presc_q <= '0;
            mctl_q  <= '0;
            flags_q <= '0;
        end else begin
            ctrl_q  <= ctrl_d;
            if (wr_presc) presc_q <= reg_wdata[PRE_W-1:0];
            if (wr_mctl)  mctl_q  <= reg_wdata[MCTL_W-1:0];
            flags_q <= (flags_q & ~(wr_flags ? reg_wdata[NUM_MATCH-1:0] : '0)) | hit;
        end
    end

    assign irq = |flags_q;

    pwmt_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .enable (run_en),
        .clear  (hold),
        .limit  (presc_q),
        .tick   (tick)
    );

    pwmt_match_bank #(.CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH)) u_bank (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_match),
        .wr_idx      (slot_idx),
        .wr_data     (reg_wdata[CNT_W-1:0]),
        .shadow_mode (pwm_mode),
        .rel_set     (rel_set),
        .apply       (wrap && pwm_mode),
        .active      (active),
        .next_active (next_active),
        .pending     (pending)
    );

    pwmt_counter #(.CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .hold      (hold),
        .pwm_mode  (pwm_mode),
        .active    (active),
        .reset_sel (reset_sel),
        .stop_sel  (stop_sel),
        .count     (count),
        .hit       (hit),
        .wrap      (wrap),
        .stop_req  (stop_req)
    );

    pwmt_outputs #(.CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH)) u_out (
        .clk         (clk),
        .rst         (rst),
        .pwm_mode    (pwm_mode),
        .tick        (tick),
        .wrap        (wrap),
        .count       (count),
        .next_active (next_active),
        .pwm_out     (pwm_out)
    );

    always_comb begin
        reg_rdata = '0;
        if (slot_valid(reg_addr, NUM_MATCH)) begin
            reg_rdata = DATA_W'(active[slot_idx]);
        end else begin
            case (reg_addr)
                A_CTRL:  reg_rdata = DATA_W'(ctrl_q);
                A_PRESC: reg_rdata = DATA_W'(presc_q);
                A_COUNT: reg_rdata = DATA_W'(count);
                A_FLAGS: reg_rdata = DATA_W'(flags_q);
                A_MCTL:  reg_rdata = DATA_W'(mctl_q);
                A_REL:   reg_rdata = DATA_W'(pending);
                default: reg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/pwmt_checker.sv
module pwmt_checker #(
    parameter int CNT_W     = 32,
    parameter int NUM_MATCH = 4
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            tick,
    input logic                            hold,
    input logic                            pwm_mode,
    input logic                            wrap,
    input logic                            rel_wr,
    input logic [CNT_W-1:0]                count,
    input logic [NUM_MATCH-1:0][CNT_W-1:0] active,
    input logic [NUM_MATCH-1:0]            pending,
    input logic [NUM_MATCH-1:0]            hit,
    input logic [NUM_MATCH-1:0]            flags,
    input logic [NUM_MATCH-2:0]            pwm_out
);
    assert_hold_clears_R1: assert property (@(posedge clk) disable iff (rst)
        hold |=> (count == '0));

    assert_idle_stable_R1: assert property (@(posedge clk) disable iff (rst)
        (!tick && !hold) |=> $stable(count));

    assert_period_restart_R2: assert property (@(posedge clk) disable iff (rst)
        (pwm_mode && tick && !hold && (count == active[0])) |=> (count == '0));

    assert_timer_outputs_low_R3: assert property (@(posedge clk) disable iff (rst)
        !pwm_mode |=> (pwm_out == '0));

    assert_live_held_R4: assert property (@(posedge clk) disable iff (rst)
        (pwm_mode && !wrap) |=> $stable(active));

    assert_release_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (wrap && pwm_mode && !rel_wr) |=> ((pending & $past(pending)) == '0));

    assert_flag_sets_R7: assert property (@(posedge clk) disable iff (rst)
        (hit != '0) |=> ((flags & $past(hit)) == $past(hit)));
endmodule

bind pwm_timer pwmt_checker #(.CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .hold     (hold),
    .pwm_mode (pwm_mode),
    .wrap     (wrap),
    .rel_wr   (wr_rel),
    .count    (count),
    .active   (active),
    .pending  (pending),
    .hit      (hit),
    .flags    (flags_q),
    .pwm_out  (pwm_out)
);

// File: tb/sim_pwm_timer.sv
`timescale 1ns/10ps
module sim_pwm_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0;
    logic [3:0]  addr = 4'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [2:0]  pwm;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    int edge_n  = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) edge_n <= edge_n + 1;

    pwm_timer u0 (
        .clk(clk), .rst(rst), .reg_we(we), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata), .pwm_out(pwm), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #0.1;
        d = rdata;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int r0, k, kl, kw, meff;
        logic [2:0] exp_v;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11: reset state
        rd(4'd0, v); chk("R11 ctrl", v, 0);
        rd(4'd1, v); chk("R11 presc", v, 0);
        rd(4'd2, v); chk("R11 count", v, 0);
        rd(4'd3, v); chk("R11 flags", v, 0);
        rd(4'd5, v); chk("R11 release", v, 0);
        rd(4'd8, v); chk("R11 cmp0", v, 0);
        chk("R11 pwm", {29'd0, pwm}, 0);
        chk("R11 irq", {31'd0, irq}, 0);

        // keep all compares out of reach in timer mode
        wr(4'd2 == 4'd2 ? 4'd0 : 4'd0, 32'h2);
        for (int i = 0; i < 4; i++) wr(4'(8 + i), 32'd1000);
        wr(4'd3, 32'hF);

        // R1: prescale sweep
        for (int p = 0; p < 4; p++) begin
            wr(4'd0, 32'h2);
            wr(4'd1, 32'(p));
            wr(4'd0, 32'h1);
            r0 = edge_n;
            for (int j = 0; j < 12; j++) begin
                @(negedge clk);
                k = edge_n - r0;
                rd(4'd2, v);
                chk("R1 prescaled count", v, 32'(k / (p + 1)));
            end
            wr(4'd0, 32'h3);
            @(negedge clk);
            rd(4'd2, v); chk("R1 hold zero", v, 0);
            repeat (3) @(negedge clk);
            rd(4'd2, v); chk("R1 hold stays zero", v, 0);
        end

        // R6, R9, R7: timer reset-on-match
        wr(4'd1, 32'd0);
        wr(4'd3, 32'hF);
        wr(4'd9, 32'd5);
        rd(4'd9, v); chk("R6 direct write", v, 5);
        wr(4'd4, 32'h4);
        wr(4'd0, 32'h1);
        r0 = edge_n;
        for (int j = 0; j < 20; j++) begin
            @(negedge clk);
            k = edge_n - r0;
            rd(4'd2, v);
            chk("R9 count wraps at compare1", v, 32'(k % 6));
            rd(4'd3, v);
            chk("R7 flag1", v, (k >= 6) ? 32'h2 : 32'h0);
            chk("R7 irq", {31'd0, irq}, (k >= 6) ? 32'h1 : 32'h0);
        end
        wr(4'd0, 32'h0);
        wr(4'd3, 32'h0);
        rd(4'd3, v); chk("R8 write zero keeps flag", v, 32'h2);
        wr(4'd3, 32'h2);
        rd(4'd3, v); chk("R8 write one clears flag", v, 0);
        chk("R8 irq low", {31'd0, irq}, 0);

        // R10: stop-on-match
        wr(4'd0, 32'h2);
        wr(4'd9, 32'd1000);
        wr(4'd10, 32'd9);
        wr(4'd4, 32'h20);
        wr(4'd0, 32'h1);
        r0 = edge_n;
        repeat (5) @(negedge clk);
        rd(4'd2, v); chk("R10 running", v, 32'(edge_n - r0));
        repeat (12) @(negedge clk);
        rd(4'd2, v); chk("R10 halted count", v, 10);
        rd(4'd0, v); chk("R10 run bit cleared", v & 32'h1, 0);
        rd(4'd3, v); chk("R10 flag2", v & 32'h4, 32'h4);
        wr(4'd4, 32'h0);
        wr(4'd10, 32'd1000);
        wr(4'd3, 32'hF);

        // R2, R3: PWM sweep
        for (int m0 = 1; m0 <= 4; m0++) begin
            for (int mb = 0; mb <= m0 + 1; mb++) begin
                wr(4'd0, 32'h2);
                wr(4'd8, 32'(m0));
                wr(4'd9, 32'(mb));
                wr(4'd10, 32'(mb + 1));
                wr(4'd11, 32'(m0 + 1));
                wr(4'd0, 32'h5);
                r0 = edge_n;
                for (int j = 0; j < 3 * (m0 + 1); j++) begin
                    @(negedge clk);
                    k = edge_n - r0;
                    if (k >= m0 + 1) begin
                        exp_v[0] = (k % (m0 + 1)) < mb;
                        exp_v[1] = (k % (m0 + 1)) < mb + 1;
                        exp_v[2] = 1'b1;
                    end else begin
                        exp_v = 3'b000;
                    end
                    chk("R3 pwm levels", {29'd0, pwm}, {29'd0, exp_v});
                    rd(4'd2, v);
                    chk("R2 period count", v, 32'(k % (m0 + 1)));
                end
            end
        end
        wr(4'd0, 32'h2);
        @(negedge clk);
        chk("R3 timer mode low", {29'd0, pwm}, 0);

        // R4, R5: held and released compare update
        wr(4'd8, 32'd7);
        wr(4'd9, 32'd4);
        wr(4'd0, 32'h5);
        r0 = edge_n;
        wr(4'd9, 32'd2);
        rd(4'd9, v); chk("R4 live unchanged", v, 4);
        for (int j = 0; j < 24; j++) begin
            @(negedge clk);
            k = edge_n - r0;
            if (k >= 8) chk("R4 old duty", {31'd0, pwm[0]}, ((k % 8) < 4) ? 32'h1 : 32'h0);
            rd(4'd9, v); chk("R4 live readback", v, 4);
            rd(4'd5, v); chk("R4 nothing pending", v, 0);
        end
        wr(4'd5, 32'h2);
        kl = edge_n - r0;
        kw = (kl / 8 + 1) * 8;
        for (int j = 0; j < 20; j++) begin
            @(negedge clk);
            k = edge_n - r0;
            meff = (k >= kw) ? 2 : 4;
            chk("R5 duty switch", {31'd0, pwm[0]}, ((k % 8) < meff) ? 32'h1 : 32'h0);
            rd(4'd9, v); chk("R5 live at boundary", v, 32'(meff));
            rd(4'd5, v); chk("R5 pending bit", v, (k < kw) ? 32'h2 : 32'h0);
        end

        finish_run();
    end
endmodule